// File: doc/BRIEF.md
# Bridge Trim Calibration Sequencer

This block runs the automatic trim search for a split capacitor array whose bridge capacitor is built deliberately too large. A digital trim word selects how many parallel trim capacitors hang on the node between the low and high segments. Each weighted bit of the word switches in a binary multiple of the trim unit. Adding trim lowers the weight of the low segment. The goal is a low segment that weighs the same as one unit capacitor of the high segment.

On a start pulse the sequencer clears the trim word to zero and turns on the test pattern. The pattern sets the low segment against one high-segment unit, so the comparator reports which one is heavier. At each code the sequencer waits a programmable number of settle clocks and then samples the comparator for one cycle. While the low segment still reads heavier, the sequencer raises the code by one and compares again. At the first code where the comparator answer flips, it steps back to the previous code and holds that code for normal conversions. Two outcomes raise an error flag: the ramp reaches all ones without a flip, or the answer is already flipped at code zero. While the search runs, normal conversion requests are not granted.

Top module: `trim_cal_seq`

## Requirements
- R1: After reset, `busy`, `done`, `trim_err`, `pattern_on` and `cmp_strobe` are 0 and `trim_code` is 0.
- R2: A `cal_start` pulse sampled while idle makes `busy` and `pattern_on` 1 and `trim_code` 0 on the next cycle, and clears `done` and `trim_err`.
- R3: Each trim code is held for `settle_cycles`+1 clocks. This is followed by one clock with `cmp_strobe` high, during which `cmp_hi` is taken. A search that takes n samples therefore keeps `busy` high for n*(`settle_cycles`+2) clocks.
- R4: When `cmp_hi` is 1 (low segment heavier) at a strobe and the code is below all ones, the code rises by exactly 1. The k-th strobe of a search (counting from 0) happens at code k.
- R5: When `cmp_hi` is 0 at a strobe with code k>0, the block stops with `trim_code`=k-1, `done`=1, `trim_err`=0 and `busy`=0.
- R6: When `cmp_hi` is 1 at a strobe with code all ones (63), the block stops with `trim_code`=63, `done`=1 and `trim_err`=1.
- R7: When `cmp_hi` is 0 at the first strobe (code 0), the block stops with `trim_code`=0, `done`=1 and `trim_err`=1.
- R8: After a search ends, `trim_code` stays fixed whatever `cmp_hi` does, until the next `cal_start`.
- R9: A `cal_start` pulse while `busy` is high has no effect. The search keeps its timing and its result.
- R10: `conv_grant` follows `conv_req` while `busy` is 0 and is 0 while `busy` is 1.
- R11: `settle_cycles` is captured at `cal_start`. Changes during a search do not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | Start-of-calibration pulse |
| settle_cycles | input | 8 | Settle wait per code, in clocks, minus one |
| cmp_hi | input | 1 | Comparator: 1 = low segment outweighs one high unit |
| conv_req | input | 1 | Normal conversion request |
| trim_code | output | 6 | Trim capacitor select word |
| pattern_on | output | 1 | Applies the calibration test pattern to the array switches |
| cmp_strobe | output | 1 | High in the cycle the comparator is sampled |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished, code held |
| trim_err | output | 1 | Search ended without a usable flip |
| conv_grant | output | 1 | Conversion request passed through |

## Verification
The hardest cases to reach are the two ends of the ramp. One is a comparator that never flips, so the word must climb all 63 steps and stop at all ones without wrapping. The other is a comparator that is already flipped at code zero. The bench models the array as a flip threshold on the trim code and sweeps that threshold over every value from 0 to 64, under several settle counts. Each run therefore hits every possible stopping code and both error ends, and the bench predicts the run length and the final word from the threshold. Separate runs inject a second start pulse and a changed settle count in the middle of a search.

// File: rtl/trim_cal_pkg.sv
package trim_cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_SAMPLE = 2'd2
  } cal_state_t;
endpackage

// File: rtl/trim_settle_timer.sv
module trim_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expired = (cnt_q == limit);
  assign cnt_en  = restart | (run & ~expired);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)        cnt_d = '0;
    else if (run)       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3: the count never runs past the limit while waiting
  a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && expired) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/trim_code_ramp.sv
module trim_code_ramp #(
  parameter int TRIM_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step_up,
  input  logic              step_back,
  output logic [TRIM_W-1:0] code,
  output logic              at_max,
  output logic              at_zero
);
  logic [TRIM_W-1:0] code_q, code_d;
  logic              code_en;

  assign code    = code_q;
  assign at_max  = &code_q;
  assign at_zero = (code_q == '0);
  assign code_en = clear | step_up | step_back;

  always_comb begin
    code_d = code_q;
    if (clear)          code_d = '0;
    else if (step_up)   code_d = code_q + 1'b1;
    else if (step_back) code_d = code_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  // R4: the word only moves by one unit or returns to zero
  a_r4_unit_move: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_q) |-> (code_q == $past(code_q) + 1'b1) ||
                         (code_q == $past(code_q) - 1'b1) || (code_q == '0));
  // R6: never asked to wrap past all ones
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |-> !at_max);
  // R7: never asked to step below zero
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    step_back |-> !at_zero);
endmodule

// File: rtl/trim_cal_seq.sv
module trim_cal_seq
  import trim_cal_pkg::*;
#(
  parameter int TRIM_W   = 6,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cal_start,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                cmp_hi,
  input  logic                conv_req,
  output logic [TRIM_W-1:0]   trim_code,
  output logic                pattern_on,
  output logic                cmp_strobe,
  output logic                busy,
  output logic                done,
  output logic                trim_err,
  output logic                conv_grant
);
  cal_state_t          state_q, state_d;
  logic [SETTLE_W-1:0] settle_q;
  logic                done_q, done_d, err_q, err_d;
  logic                start_ok, wait_over;
  logic                ramp_clear, ramp_up, ramp_back, tmr_restart;
  logic                at_max, at_zero;

  assign start_ok = cal_start && (state_q == ST_IDLE);

  always_comb begin
    state_d     = state_q;
    done_d      = done_q;
    err_d       = err_q;
    ramp_clear  = 1'b0;
    ramp_up     = 1'b0;
    ramp_back   = 1'b0;
    tmr_restart = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cal_start) begin
        state_d     = ST_SETTLE;
        done_d      = 1'b0;
        err_d       = 1'b0;
        ramp_clear  = 1'b1;
        tmr_restart = 1'b1;
      end
      ST_SETTLE: if (wait_over) state_d = ST_SAMPLE;
      ST_SAMPLE: begin
        if (cmp_hi && !at_max) begin
          ramp_up     = 1'b1;
          tmr_restart = 1'b1;
          state_d     = ST_SETTLE;
        end else begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          if (cmp_hi || at_zero) err_d = 1'b1;
          else                   ramp_back = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        settle_q <= '0;
    else if (start_ok) settle_q <= settle_cycles;
  end

  trim_settle_timer #(.CNT_W(SETTLE_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .run     (state_q == ST_SETTLE),
    .limit   (settle_q),
    .expired (wait_over)
  );

  trim_code_ramp #(.TRIM_W(TRIM_W)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (ramp_clear),
    .step_up   (ramp_up),
    .step_back (ramp_back),
    .code      (trim_code),
    .at_max    (at_max),
    .at_zero   (at_zero)
  );

  assign busy       = (state_q != ST_IDLE);
  assign pattern_on = busy;
  assign cmp_strobe = (state_q == ST_SAMPLE);
  assign done       = done_q;
  assign trim_err   = err_q;
  assign conv_grant = conv_req & ~busy;

  // R2: a search always begins at code zero
  a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (trim_code == '0) && !done && !trim_err);
  // R3: a sample cycle is always preceded by a settle cycle
  a_r3_sample_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_strobe |-> $past(state_q) == ST_SETTLE);
  // R6: an error is only reported with a finished search
  a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    trim_err |-> done && !busy);
  // R8: the held code does not move while idle
  a_r8_hold_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cal_start) |=> $stable(trim_code));
  // R10: no conversion is granted while calibrating
  a_r10_block_conv: assert property (@(posedge clk) disable iff (!rst_n)
    pattern_on |-> !conv_grant);
endmodule

// File: tb/trim_cal_seq_test.sv
module trim_cal_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cal_start = 1'b0;
  logic [7:0] settle_cycles = 8'd0;
  logic       cmp_hi;
  logic       conv_req = 1'b0;
  logic [5:0] trim_code;
  logic       pattern_on, cmp_strobe, busy, done, trim_err, conv_grant;

  int thr = 0;
  int errors = 0;
  int checks = 0;
  int cycles_total = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // array model: low segment heavier while trim is below the threshold
  assign cmp_hi = (int'(trim_code) < thr);

  trim_cal_seq uut (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start),
    .settle_cycles(settle_cycles), .cmp_hi(cmp_hi), .conv_req(conv_req),
    .trim_code(trim_code), .pattern_on(pattern_on), .cmp_strobe(cmp_strobe),
    .busy(busy), .done(done), .trim_err(trim_err), .conv_grant(conv_grant)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles_total++;
    if (cycles_total > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles_total, 150000);
      finish_run();
    end
  end

  task automatic run_cal(input int t, input int s, input bit disturb);
    int exp_n, exp_code, exp_err, cyc, idx;
    bit order_ok;
    thr = t;
    settle_cycles = 8'(s);
    @(negedge clk) cal_start = 1'b1;
    @(negedge clk) cal_start = 1'b0;
    check(busy && pattern_on && trim_code == 0 && !done && !trim_err,
          "R2 start", int'(trim_code), 0);
    exp_n    = (t == 0) ? 1 : (t <= 63 ? t + 1 : 64);
    exp_code = (t == 0) ? 0 : (t <= 63 ? t - 1 : 63);
    exp_err  = (t == 0 || t >= 64) ? 1 : 0;
    cyc = 0; idx = 0; order_ok = 1'b1;
    while (busy && cyc < 20000) begin
      cyc++;
      if (cmp_strobe) begin
        if (int'(trim_code) != idx) order_ok = 1'b0;
        idx++;
      end
      if (cyc == 2) begin
        conv_req = 1'b1;
        #1;
        check(!conv_grant, "R10 blocked while busy", int'(conv_grant), 0);
        conv_req = 1'b0;
      end
      if (disturb && cyc == 3) begin
        cal_start = 1'b1;        // R9 ignored second start
        settle_cycles = 8'd9;    // R11 ignored settle change
      end
      if (disturb && cyc == 4) cal_start = 1'b0;
      @(negedge clk);
    end
    settle_cycles = 8'(s);
    check(order_ok && idx == exp_n, "R4 strobe codes", idx, exp_n);
    check(cyc == exp_n * (s + 2), disturb ? "R3 R9 R11 duration" : "R3 duration",
          cyc, exp_n * (s + 2));
    check(done && int'(trim_code) == exp_code,
          (t == 0) ? "R7 code" : (t >= 64 ? "R6 code" : "R5 code"),
          int'(trim_code), exp_code);
    check(int'(trim_err) == exp_err,
          (t == 0) ? "R7 err" : (t >= 64 ? "R6 err" : "R5 err"),
          int'(trim_err), exp_err);
  endtask

  initial begin
    #1;
    check(!busy && !done && !trim_err && !pattern_on && !cmp_strobe && trim_code == 0,
          "R1 reset", int'(busy), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && trim_code == 0, "R1 after release", int'(trim_code), 0);

    for (int s = 0; s < 4; s += 3) begin
      for (int t = 0; t <= 64; t++) run_cal(t, s, 1'b0);
    end
    for (int t = 0; t <= 64; t += 8) run_cal(t, 1, 1'b0);

    // R9 / R11 disturbance during a search
    run_cal(30, 1, 1'b1);
    run_cal(64, 2, 1'b1);

    // R8: held code ignores the comparator after completion
    run_cal(20, 0, 1'b0);
    thr = 0;
    repeat (5) @(negedge clk);
    check(trim_code == 19 && done && !busy, "R8 hold low cmp", int'(trim_code), 19);
    thr = 64;
    repeat (5) @(negedge clk);
    check(trim_code == 19 && done && !busy, "R8 hold high cmp", int'(trim_code), 19);

    // R10: grant passes when idle
    conv_req = 1'b1;
    #1;
    check(conv_grant, "R10 grant idle", int'(conv_grant), 1);
    conv_req = 1'b0;
    #1;
    check(!conv_grant, "R10 no request", int'(conv_grant), 0);

    finish_run();
  end
endmodule